// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external SPI master read and write a bank of 21 eight-bit control and status registers. It runs on a fast local clock and oversamples the SPI lines, so SCLK, slave select and MOSI enter through synchronizers and each SCLK edge becomes a one-cycle pulse. Every transaction opens with a command byte. The command byte names the register, gives the transfer direction and can carry an acknowledge flag. That flag sets a status bit in register 9 as a side effect, so firmware saves a separate write. Any number of data bytes can follow, and all of them address the same register until slave select is released.

Two wiring modes are supported. In full-duplex mode MISO is a separate line. While the command byte is clocked in, MISO carries a byte of eight interrupt-request flags that was captured when select fell. In half-duplex mode MISO is never driven. For a read, the slave takes over the shared MOSI line once the command byte is complete. A mode bit in register 17 picks the mode. Register 20 shows four general-purpose input pins in its upper nibble.

Top module: `spi_regif`

## Requirements
- R1: Bits shift most significant first in SPI mode 0. MOSI is sampled on the rising SCLK edge, the slave updates its output after the falling edge, and SCLK idles low.
- R2: The command byte is bits 7..3 = register address, bit 2 = 0, bit 1 = direction (1 = write, 0 = read), bit 0 = acknowledge flag.
- R3: A write to an address from 0 to 20 stores the data byte. Each further data byte in the same select window goes to the same address, and the last one is kept. Writes to addresses 21..31 have no effect, and reads from them return 0x00.
- R4: A command byte with the acknowledge flag set sets bit 0 of register 9. A write to register 9 replaces that bit like any other bit.
- R5: In full-duplex mode MISO carries irq_i[7:0], captured when select is asserted, during the command byte, bit 7 first.
- R6: In full-duplex mode miso_oe_o is low whenever slave select is high.
- R7: In half-duplex mode miso_oe_o stays low. mosi_oe_o rises only after the 8th rising SCLK edge of a read command and stays low for write commands.
- R8: A read returns the addressed register's value. Its MSB is valid before the 9th rising SCLK edge, and repeated data bytes return the register again.
- R9: Register 20 reads gpin_i[3:0] on bits 7..4, and writes do not change those bits. Its bits 3..0 are ordinary read/write storage.
- R10: Bit 4 of register 17 selects full-duplex (1) or half-duplex (0). A change takes effect only after slave select goes high, and the mode after reset is half-duplex.
- R11: Deasserting select in the middle of a byte discards that byte and resets the bit counter, so the next transaction starts on a command byte.
- R12: After reset all registers read 0 apart from the input nibble of register 20, and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock, at least 8x SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock |
| ss_ni | input | 1 | SPI slave select, active low |
| mosi_i | input | 1 | MOSI input (shared data line in half-duplex) |
| mosi_o | output | 1 | Read data driven onto the shared line in half-duplex |
| mosi_oe_o | output | 1 | Drive enable for the shared line |
| miso_o | output | 1 | MISO data in full-duplex |
| miso_oe_o | output | 1 | MISO drive enable |
| irq_i | input | 8 | Interrupt-request flags returned during the command byte |
| gpin_i | input | 4 | General-purpose input levels |
| regs_o | output | 168 | All registers flattened, register n on bits 8n+7..8n |

## Verification
A misaligned bit counter shows up within one byte, either as read data rotated by one bit or as a write stored in the wrong register. A stale or corrupted mode flag drives the wrong enable in the first transaction after select rises, so MISO is driven in half-duplex mode or the status byte is missing in full-duplex mode. A lost acknowledge pulse or a wrong address decode is visible in regs_o a few clock cycles after the command byte. A byte cut off by select going high must leave regs_o unchanged, and the next read must come back correctly aligned.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int NUM_REGS = 21;
  localparam int GPIN_W   = 4;
  localparam int ACK_REG  = 9;
  localparam int ACK_BIT  = 0;
  localparam int CFG_REG  = 17;
  localparam int MODE_BIT = 4;
  localparam int GPIO_REG = 20;
  localparam int CNT_W    = $clog2(DATA_W);
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic ss_ni,
  input  logic mosi_i,
  output logic sel_o,
  output logic start_o,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o
);
  localparam logic [2:0] IDLE = 3'b010; // {mosi, ss_n, sclk}

  logic [2:0] stg_q [STAGES];
  logic       sclk_prev_q, sel_prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= IDLE;
      else if (i == 0) stg_q[i] <= {mosi_i, ss_ni, sclk_i};
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  logic sclk_s, sel_s;
  assign sclk_s = stg_q[STAGES-1][0];
  assign sel_s  = ~stg_q[STAGES-1][1];
  assign mosi_o = stg_q[STAGES-1][2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      sel_prev_q  <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      sel_prev_q  <= sel_s;
    end
  end

  assign sel_o   = sel_s;
  assign start_o = sel_s & ~sel_prev_q;
  assign rise_o  = sel_s & sclk_s & ~sclk_prev_q;
  assign fall_o  = sel_s & ~sclk_s & sclk_prev_q;
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              start_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              ack_set_o,
  output logic              cmd_done_o,
  output logic              dir_wr_o,
  output logic              out_bit_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W-1);

  logic [DATA_W-1:0] sh_q, out_q, nb;
  logic [CNT_W-1:0]  cnt_q;
  logic              ld_q;

  assign nb = {sh_q[DATA_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      out_q      <= '0;
      cnt_q      <= '0;
      ld_q       <= 1'b0;
      addr_o     <= '0;
      wr_o       <= 1'b0;
      wdata_o    <= '0;
      ack_set_o  <= 1'b0;
      cmd_done_o <= 1'b0;
      dir_wr_o   <= 1'b0;
    end else begin
      wr_o      <= 1'b0;
      ack_set_o <= 1'b0;
      ld_q      <= 1'b0;
      if (ld_q) out_q <= rdata_i;
      if (!sel_i) begin
        cnt_q      <= '0;
        cmd_done_o <= 1'b0;
        dir_wr_o   <= 1'b0;
      end else if (start_i) begin
        out_q <= status_i;
      end else if (rise_i) begin
        sh_q  <= nb;
        cnt_q <= CNT_W'(cnt_q + 1'b1);
        if (cnt_q == LAST) begin
          ld_q <= 1'b1;
          if (!cmd_done_o) begin
            addr_o     <= nb[DATA_W-1 -: ADDR_W];
            dir_wr_o   <= nb[1];
            ack_set_o  <= nb[0];
            cmd_done_o <= 1'b1;
          end else if (dir_wr_o) begin
            wr_o    <= 1'b1;
            wdata_o <= nb;
          end
        end
      end else if (fall_i && cnt_q != '0) begin
        // hold MSB across the byte boundary fall
        out_q <= {out_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign out_bit_o = out_q[DATA_W-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regif_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sel_i,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       ack_set_i,
  input  logic [GPIN_W-1:0]          gpin_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       fdx_o
);
  localparam int LO_W = DATA_W - GPIN_W;

  logic [DATA_W-1:0] view [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_i && (addr_i == ADDR_W'(i));
    if (i == GPIO_REG) begin : g_gpio
      logic [LO_W-1:0] lo_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lo_q <= '0;
        else if (hit) lo_q <= wdata_i[LO_W-1:0];
      end
      assign view[i] = {gpin_i, lo_q};
    end else if (i == ACK_REG) begin : g_ack
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (hit) q <= wdata_i;
        else if (ack_set_i) q[ACK_BIT] <= 1'b1;
      end
      assign view[i] = q;
    end else begin : g_plain
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (hit) q <= wdata_i;
      end
      assign view[i] = q;
    end
    assign regs_o[i*DATA_W +: DATA_W] = view[i];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(NUM_REGS)) rdata_o = view[addr_i];
  end

  // mode only follows the config bit while deselected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fdx_o <= 1'b0;
    else if (!sel_i) fdx_o <= view[CFG_REG][MODE_BIT];
  end
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       ss_ni,
  input  logic                       mosi_i,
  output logic                       mosi_o,
  output logic                       mosi_oe_o,
  output logic                       miso_o,
  output logic                       miso_oe_o,
  input  logic [DATA_W-1:0]          irq_i,
  input  logic [GPIN_W-1:0]          gpin_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic sel, start, rise, fall, mosi_s;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  logic wr, ack_set, cmd_done, dir_wr, out_bit, fdx;

  spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .ss_ni, .mosi_i,
    .sel_o(sel), .start_o(start), .rise_o(rise), .fall_o(fall), .mosi_o(mosi_s)
  );

  spi_frame u_frame (
    .clk_i, .rst_ni,
    .sel_i(sel), .start_i(start), .rise_i(rise), .fall_i(fall), .mosi_i(mosi_s),
    .status_i(irq_i), .rdata_i(rdata),
    .addr_o(addr), .wr_o(wr), .wdata_o(wdata), .ack_set_o(ack_set),
    .cmd_done_o(cmd_done), .dir_wr_o(dir_wr), .out_bit_o(out_bit)
  );

  spi_reg_bank u_bank (
    .clk_i, .rst_ni, .sel_i(sel),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .ack_set_i(ack_set),
    .gpin_i, .rdata_o(rdata), .regs_o, .fdx_o(fdx)
  );

  assign miso_o    = out_bit;
  assign miso_oe_o = fdx & sel;
  assign mosi_o    = out_bit;
  assign mosi_oe_o = ~fdx & sel & cmd_done & ~dir_wr;
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk
  import spi_regif_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sel,
  input logic                       fdx,
  input logic                       cmd_done,
  input logic                       ack_set,
  input logic                       wr,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          wdata,
  input logic [NUM_REGS*DATA_W-1:0] regs_o,
  input logic                       miso_oe_o,
  input logic                       mosi_oe_o
);
  p_miso_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |-> !miso_oe_o);

  p_half_no_miso_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fdx |-> !miso_oe_o);

  p_turnaround_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mosi_oe_o |-> (cmd_done && !fdx));

  p_no_contention_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(miso_oe_o && mosi_oe_o));

  p_ack_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_set && !(wr && addr == ADDR_W'(ACK_REG))) |=> regs_o[ACK_REG*DATA_W + ACK_BIT]);

  p_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr == '0) |=> regs_o[DATA_W-1:0] == $past(wdata));

  p_mode_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && $past(sel)) |-> $stable(fdx));
endmodule

bind spi_regif spi_regif_chk u_chk (
  .clk_i, .rst_ni, .sel, .fdx, .cmd_done, .ack_set, .wr, .addr, .wdata,
  .regs_o, .miso_oe_o, .mosi_oe_o
);

// File: tb/spi_regif_tb_top.sv
`timescale 1ns/1ps
module spi_regif_tb_top;
  localparam int NREG = 21;
  localparam int HP   = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic mosi_o, mosi_oe, miso_o, miso_oe;
  logic [7:0] irq = '0;
  logic [3:0] gpin = '0;
  logic [NREG*8-1:0] regs;

  always #2.5 clk = ~clk;

  spi_regif dut_i (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .ss_ni(ss_n), .mosi_i(mosi),
    .mosi_o, .mosi_oe_o(mosi_oe), .miso_o, .miso_oe_o(miso_oe),
    .irq_i(irq), .gpin_i(gpin), .regs_o(regs)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] model [NREG];
  logic fd = 1'b0;
  logic [7:0] tx_b [4];
  logic [7:0] rx_b [4];
  logic [7:0] st_b;
  logic moe7, moe8, miso_seen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] view(input int a);
    if (a >= NREG) return 8'h00;
    if (a == 20) return {gpin, model[20][3:0]};
    return model[a];
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // abort < 0: full transfer; else stop after that many bits
  task automatic xfer(input logic [7:0] cmd, input int nb, input int abort);
    int a;
    a = int'(cmd[7:3]);
    miso_seen = 1'b0;
    ss_n = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < 8*(nb+1); i++) begin
      int k, j;
      logic r;
      if (abort >= 0 && i == abort) break;
      k = i / 8; j = 7 - (i % 8);
      if (k == 0) mosi = cmd[j];
      else if (cmd[1] || fd) mosi = tx_b[k-1][j];
      wait_clk(HP);
      r = fd ? miso_o : mosi_o;
      if (k == 0) st_b[j] = miso_o;
      else rx_b[k-1][j] = r;
      if (i == 7) moe7 = mosi_oe;
      if (i == 8) moe8 = mosi_oe;
      miso_seen |= miso_oe;
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
    end
    wait_clk(HP);
    ss_n = 1'b1;
    wait_clk(2*HP);
    if (abort < 0) begin
      if (cmd[0]) model[9][0] = 1'b1;
      if (cmd[1] && nb > 0 && a < NREG) begin
        if (a == 20) model[20][3:0] = tx_b[nb-1][3:0];
        else model[a] = tx_b[nb-1];
      end
    end
    fd = model[17][4];
  endtask

  task automatic wr_reg(input int a, input logic [7:0] d);
    tx_b[0] = d;
    xfer({5'(a), 3'b010}, 1, -1);
  endtask

  task automatic rd_reg(input int a, input int nb, input string req);
    xfer({5'(a), 3'b000}, nb, -1);
    for (int k = 0; k < nb; k++) chk(req, rx_b[k], view(a));
  endtask

  task automatic chk_regs(input string req);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NREG; i++) if (regs[i*8 +: 8] !== view(i)) ok = 1'b0;
    chk(req, ok, 1'b1);
  endtask

  initial begin : watchdog
    wait_clk(190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(1234));
    for (int i = 0; i < NREG; i++) model[i] = '0;
    wait_clk(4);
    // R12: reset state
    chk("R12 regs", regs, '0);
    chk("R12 oe", {miso_oe, mosi_oe}, 2'b00);
    rst_ni = 1'b1;
    wait_clk(4);

    // R1 R2 R3: write then read, half-duplex
    wr_reg(3, 8'hA5);
    chk("R3 write", regs[3*8 +: 8], 8'hA5);
    rd_reg(3, 1, "R8 read hd");
    chk("R7 oe before 8th rise", moe7, 1'b0);
    chk("R7 oe after 8th rise", moe8, 1'b1);
    chk("R7 miso hiz hd", miso_seen, 1'b0);
    // R7: write command never turns the line around
    tx_b[0] = 8'h3C;
    xfer({5'd4, 3'b010}, 1, -1);
    chk("R7 write no oe", moe8, 1'b0);

    // R3: multi-byte write, last byte kept; reads repeat
    tx_b[0] = 8'h11; tx_b[1] = 8'h22; tx_b[2] = 8'h96;
    xfer({5'd5, 3'b010}, 3, -1);
    chk("R3 multi write", regs[5*8 +: 8], 8'h96);
    rd_reg(5, 3, "R8 repeat read");
    // R3: out-of-range addresses
    wr_reg(25, 8'hFF);
    chk_regs("R3 oob write ignored");
    rd_reg(31, 1, "R3 oob read zero");

    // R9: general-purpose input nibble
    gpin = 4'h5;
    wr_reg(20, 8'hFF);
    chk("R9 gpin read-only", regs[20*8 +: 8], 8'h5F);
    gpin = 4'hA;
    rd_reg(20, 1, "R9 gpin read");

    // R4: acknowledge flag
    xfer({5'd0, 3'b001}, 0, -1);
    chk("R4 ack sets", regs[9*8], 1'b1);
    wr_reg(9, 8'h40);
    chk("R4 write clears", regs[9*8 +: 8], 8'h40);
    tx_b[0] = 8'h00;
    xfer({5'd9, 3'b011}, 1, -1);
    chk("R4 ack then write", regs[9*8 +: 8], 8'h00);

    // R11: abort mid-byte
    tx_b[0] = 8'hFF;
    xfer({5'd3, 3'b010}, 1, 12);
    chk("R11 abort no write", regs[3*8 +: 8], 8'hA5);
    rd_reg(3, 1, "R11 realign");

    // R10: mode switch frozen until select high
    tx_b[0] = 8'h10;
    xfer({5'd17, 3'b010}, 1, -1);
    chk("R10 no miso in switching xfer", miso_seen, 1'b0);
    chk("R10 fd now", fd, 1'b1);
    // R5: status byte
    irq = 8'hC3;
    rd_reg(3, 1, "R8 read fd");
    chk("R5 status", st_b, 8'hC3);
    chk("R7 no mosi oe fd", moe8, 1'b0);
    chk("R6 miso oe low idle", miso_oe, 1'b0);
    irq = 8'h5A;
    rd_reg(20, 1, "R9 read fd");
    chk("R5 status 2", st_b, 8'h5A);

    // random mixed traffic, both modes
    for (int n = 0; n < 60; n++) begin
      int a, nb;
      a = int'($urandom_range(0, 24));
      if (a == 17) a = 2;
      nb = int'($urandom_range(1, 3));
      irq = 8'($urandom);
      gpin = 4'($urandom);
      if (n == 30) begin
        tx_b[0] = 8'h00;
        xfer({5'd17, 3'b010}, 1, -1);
      end
      if ($urandom_range(0, 1) == 1) begin
        for (int k = 0; k < nb; k++) tx_b[k] = 8'($urandom);
        xfer({5'(a), 2'b01, 1'($urandom_range(0, 1))}, nb, -1);
        chk_regs("R3 random write");
      end else begin
        logic [7:0] st_exp;
        st_exp = irq;
        rd_reg(a, nb, "R8 random read");
        if (fd) chk("R5 random status", st_b, st_exp);
      end
    end
    chk("R10 back to hd", fd, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule